// File: doc/BRIEF.md
# Clock Ratio Change Sequencer

This block produces a core clock enable and a peripheral clock enable from one reference clock. Each enable is a single-cycle pulse whose average rate is the reference rate times a multiplier, divided by a per-domain divider. Software programs the multiplier and both dividers through a small write-only register port.

A new multiplier is not applied at once. Writing one starts a settling pause: both enables are withdrawn, and an 8-bit up-counter, preloaded by software, counts prescaled ticks taken from the peripheral rate that will apply after the change. When the counter wraps from all-ones to zero, the new ratios are applied, the enables come back and the counter stops. A change to the dividers alone needs no pause. It is applied on the next cycle in which both enables pulse together. A status output is high for the whole pause, and an external clock output keeps toggling throughout.

Register map (2-bit address, 8-bit data): address 0 is the ratio register, with bits [1:0] = multiplier field M, bits [4:2] = core divider field C and bits [7:5] = peripheral divider field P. Address 1 is the settle control, with bit 0 = run bit and bits [3:1] = prescale select S. Address 2 loads the settle counter.

Top module: `clkseq_top`

## Requirements
- R1: After reset the applied fields `act_mult`, `act_cdiv`, `act_pdiv` are all 0 (multiplier 1x, both dividers 1) and `settling` is low.
- R2: With fields M, C and P applied and no pause active, `core_ce` is high in exactly M+1 cycles of any 4*(C+1) consecutive reference cycles. `per_ce` is high in exactly M+1 cycles of any 4*(P+1) consecutive cycles.
- R3: A write to address 0 whose M differs from the applied M, made while the run bit is 0 and no pause is active, raises `settling` in the next cycle. `core_ce` and `per_ce` stay low for as long as `settling` is high.
- R4: The pause lasts (256 - preload) * D(S) * T reference cycles. T is the period of the peripheral enable under the newly written M and P, counted from the start of the pause. D(S) for S = 0..7 is 1, 4, 16, 32, 64, 256, 1024, 4096.
- R5: When the counter wraps from 0xFF to 0x00, `settling` falls and the applied fields take the written values. No further pause follows without a new multiplier write.
- R6: `ck_ext` keeps toggling while `settling` is high.
- R7: A write to address 0 that keeps M unchanged but changes C or P starts no pause. The applied fields change only at the edge that ends a cycle in which `core_ce` and `per_ce` are both high.
- R8: Writes to address 0 while `settling` is high are ignored, including a write at the very edge where the counter wraps.
- R9: A write to address 0 that changes M while the run bit is 1 is ignored entirely: no pause, and the applied fields do not change.
- R10: A write to address 0 that repeats the applied fields changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| core_ce | output | 1 | Core clock enable pulse |
| per_ce | output | 1 | Peripheral clock enable pulse |
| ck_ext | output | 1 | External clock output, toggles on every core rate tick |
| settling | output | 1 | High during a settling pause |
| act_mult | output | 2 | Applied multiplier field |
| act_cdiv | output | 3 | Applied core divider field |
| act_pdiv | output | 3 | Applied peripheral divider field |

## Verification
The counter wrap that ends a pause can fall in the same cycle as a software write to the ratio register. At that edge the block both applies the pending ratios and sees a new request. The bench computes the exact pause length from R4 and places a write with a different multiplier on the wrap edge. It then checks that the first write's fields are applied, that `settling` is already low in the next cycle, and that no second pause starts.

// File: rtl/clkseq_pkg.sv
package clkseq_pkg;

  localparam int MULT_W  = 2;
  localparam int DIV_W   = 3;
  localparam int SEL_W   = 3;
  localparam int CNT_W   = 8;
  localparam int PRE_W   = 12;
  localparam int ADDR_W  = 2;
  localparam int RATIO_W = MULT_W + 2 * DIV_W;

  localparam logic [ADDR_W-1:0] ADDR_RATIO = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_SETL  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_CNT   = 2'd2;

  typedef struct packed {
    logic [DIV_W-1:0]  pdiv;
    logic [DIV_W-1:0]  cdiv;
    logic [MULT_W-1:0] mult;
  } ratio_t;

  // terminal value of the prescaler for a given select code
  function automatic logic [PRE_W-1:0] presc_lim(input logic [SEL_W-1:0] sel);
    int unsigned e;
    case (sel)
      3'd0:    e = 0;
      3'd1:    e = 2;
      3'd2:    e = 4;
      3'd3:    e = 5;
      3'd4:    e = 6;
      3'd5:    e = 8;
      3'd6:    e = 10;
      default: e = 12;
    endcase
    return PRE_W'((32'd1 << e) - 32'd1);
  endfunction

endpackage

// File: rtl/clkseq_rate_gen.sv
module clkseq_rate_gen #(
  parameter int MULT_W = 2,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic [MULT_W-1:0] mult_f,
  input  logic [DIV_W-1:0]  div_f,
  output logic              tick
);

  localparam int ACC_W = MULT_W + DIV_W + 1;

  logic [ACC_W-1:0] acc_q, acc_d, sum, thr;

  // fractional rate: add (M+1) each cycle, fire at 2^MULT_W * (D+1)
  always_comb begin
    sum  = acc_q + ACC_W'(mult_f) + ACC_W'(1);
    thr  = ACC_W'(ACC_W'(div_f) + ACC_W'(1)) << MULT_W;
    tick = (sum >= thr);
    if (clr)       acc_d = '0;
    else if (tick) acc_d = sum - thr;
    else           acc_d = sum;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/clkseq_settle.sv
module clkseq_settle
  import clkseq_pkg::*;
#(
  parameter int CNT_W_P = CNT_W,
  parameter int SEL_W_P = SEL_W,
  parameter int PRE_W_P = PRE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  logic               ptick,
  input  logic [SEL_W_P-1:0] sel,
  input  logic               cnt_we,
  input  logic [CNT_W_P-1:0] cnt_wdata,
  output logic               busy,
  output logic               ovf
);

  logic               busy_q, busy_d;
  logic [CNT_W_P-1:0] cnt_q, cnt_d;
  logic [PRE_W_P-1:0] pre_q, pre_d, pre_top;
  logic               cnt_tick;

  always_comb begin
    pre_top  = PRE_W_P'(presc_lim(SEL_W'(sel)));
    cnt_tick = busy_q && ptick && (pre_q == pre_top);
    ovf      = cnt_tick && (cnt_q == '1);

    busy_d = busy_q;
    if (start)    busy_d = 1'b1;
    else if (ovf) busy_d = 1'b0;

    pre_d = pre_q;
    if (start)                 pre_d = '0;
    else if (busy_q && ptick)  pre_d = cnt_tick ? '0 : pre_q + PRE_W_P'(1);

    cnt_d = cnt_q;
    if (cnt_we)        cnt_d = cnt_wdata;
    else if (cnt_tick) cnt_d = cnt_q + CNT_W_P'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      cnt_q  <= '0;
    end else begin
      busy_q <= busy_d;
      pre_q  <= pre_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy = busy_q;

endmodule

// File: rtl/clkseq_regs.sv
module clkseq_regs
  import clkseq_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [RATIO_W-1:0] wr_data,
  input  logic               busy,
  input  logic               ovf,
  input  logic               both_tick,
  output ratio_t             appl,
  output ratio_t             pend,
  output logic [SEL_W-1:0]   sel,
  output logic               start,
  output logic               apply_div,
  output logic               cnt_we
);

  ratio_t           appl_q, appl_d, pend_q, pend_d, new_r;
  logic             run_q, run_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             wr_ratio, wr_setl, mult_chg, accept;

  always_comb begin
    new_r    = ratio_t'(wr_data);
    wr_ratio = wr_en && (wr_addr == ADDR_RATIO);
    wr_setl  = wr_en && (wr_addr == ADDR_SETL);
    cnt_we   = wr_en && (wr_addr == ADDR_CNT);
    mult_chg = (new_r.mult != appl_q.mult);
    accept   = wr_ratio && !busy && !(mult_chg && run_q);
    start    = accept && mult_chg;

    pend_d = pend_q;
    if (accept) pend_d = new_r;

    apply_div = !busy && (pend_q != appl_q) && (pend_q.mult == appl_q.mult) && both_tick;
    appl_d = appl_q;
    if (ovf || apply_div) appl_d = pend_q;

    run_d = run_q;
    sel_d = sel_q;
    if (wr_setl) begin
      run_d = wr_data[0];
      sel_d = wr_data[SEL_W:1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      appl_q <= '0;
      pend_q <= '0;
      run_q  <= 1'b0;
      sel_q  <= '0;
    end else begin
      appl_q <= appl_d;
      pend_q <= pend_d;
      run_q  <= run_d;
      sel_q  <= sel_d;
    end
  end

  assign appl = appl_q;
  assign pend = pend_q;
  assign sel  = sel_q;

endmodule

// File: rtl/clkseq_top.sv
module clkseq_top
  import clkseq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [RATIO_W-1:0] wr_data,
  output logic              core_ce,
  output logic              per_ce,
  output logic              ck_ext,
  output logic              settling,
  output logic [MULT_W-1:0] act_mult,
  output logic [DIV_W-1:0]  act_cdiv,
  output logic [DIV_W-1:0]  act_pdiv
);

  localparam int NDOM = 2;   // 0: core, 1: peripheral

  logic [1:0]       rst_pipe;
  logic             srst_n;
  ratio_t           appl, pend, cfg;
  logic [SEL_W-1:0] sel;
  logic             start, apply_div, cnt_we, busy, ovf, clr;
  logic [NDOM-1:0]  tick;
  logic [NDOM-1:0][DIV_W-1:0] div_sel;
  logic             ck_q, ck_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign srst_n = rst_pipe[1];

  clkseq_regs u_regs (
    .clk(clk), .rst_n(srst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .ovf(ovf), .both_tick(&tick),
    .appl(appl), .pend(pend), .sel(sel), .start(start), .apply_div(apply_div), .cnt_we(cnt_we)
  );

  // during a pause the rate generators already run at the new ratios
  always_comb begin
    cfg        = busy ? pend : appl;
    div_sel[0] = cfg.cdiv;
    div_sel[1] = cfg.pdiv;
    clr        = start || ovf || apply_div;
  end

  for (genvar g = 0; g < NDOM; g++) begin : g_dom
    clkseq_rate_gen #(.MULT_W(MULT_W), .DIV_W(DIV_W)) u_rate (
      .clk(clk), .rst_n(srst_n), .clr(clr),
      .mult_f(cfg.mult), .div_f(div_sel[g]), .tick(tick[g])
    );
  end

  clkseq_settle u_settle (
    .clk(clk), .rst_n(srst_n), .start(start), .ptick(tick[1]), .sel(sel),
    .cnt_we(cnt_we), .cnt_wdata(wr_data[CNT_W-1:0]), .busy(busy), .ovf(ovf)
  );

  always_comb ck_d = ck_q ^ tick[0];

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) ck_q <= 1'b0;
    else         ck_q <= ck_d;
  end

  assign core_ce  = tick[0] && !busy;
  assign per_ce   = tick[1] && !busy;
  assign ck_ext   = ck_q;
  assign settling = busy;
  assign act_mult = appl.mult;
  assign act_cdiv = appl.cdiv;
  assign act_pdiv = appl.pdiv;

endmodule

// File: rtl/clkseq_chk.sv
module clkseq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr_en,
  input logic [1:0] wr_addr,
  input logic       settling,
  input logic       core_ce,
  input logic       per_ce,
  input logic [1:0] act_mult,
  input logic [2:0] act_cdiv,
  input logic [2:0] act_pdiv
);

  // R3: no enable pulse during a pause
  a_r3_ce_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    settling |-> (!core_ce && !per_ce));

  // R3: a pause only begins after a ratio register write
  a_r3_start_by_write: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settling) |-> $past(wr_en && (wr_addr == 2'd0)));

  // R8: applied fields hold through a pause
  a_r8_hold_in_pause: assert property (@(posedge clk) disable iff (!rst_n)
    (settling && $past(settling)) |-> $stable({act_pdiv, act_cdiv, act_mult}));

  // R7: outside a pause the fields change only after a common pulse
  a_r7_common_edge: assert property (@(posedge clk) disable iff (!rst_n)
    (!settling && !$past(settling) && ({act_pdiv, act_cdiv, act_mult} != $past({act_pdiv, act_cdiv, act_mult})))
      |-> $past(core_ce && per_ce));

endmodule

bind clkseq_top clkseq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .settling(settling),
  .core_ce(core_ce), .per_ce(per_ce), .act_mult(act_mult), .act_cdiv(act_cdiv), .act_pdiv(act_pdiv)
);

// File: tb/clkseq_top_tb_top.sv
module clkseq_top_tb_top;

  logic       clk, rst_n, wr_en;
  logic [1:0] wr_addr;
  logic [7:0] wr_data;
  logic       core_ce, per_ce, ck_ext, settling;
  logic [1:0] act_mult;
  logic [2:0] act_cdiv, act_pdiv;

  int checks = 0;
  int fails  = 0;

  clkseq_top dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .core_ce(core_ce), .per_ce(per_ce), .ck_ext(ck_ext), .settling(settling),
    .act_mult(act_mult), .act_cdiv(act_cdiv), .act_pdiv(act_pdiv)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic int act_all();
    return int'({act_pdiv, act_cdiv, act_mult});
  endfunction

  task automatic chk(input string req, input string what, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, actual, expected);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic count_ce(input int n, output int c, output int p);
    c = 0; p = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      c += int'(core_ce);
      p += int'(per_ce);
    end
  endtask

  task automatic quiet_cycles(input int n, output int highs);
    highs = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      highs += int'(settling);
    end
  endtask

  // R1, R2: reset state and rate at 1x
  task automatic t_reset();
    int c, p;
    chk("R1", "applied fields", act_all(), 0);
    chk("R1", "settling", int'(settling), 0);
    count_ce(16, c, p);
    chk("R2", "core pulses 1x/1", c, 4);
    chk("R2", "per pulses 1x/1", p, 4);
  endtask

  // R3 R4 R5 R6: full multiplier change
  task automatic t_pause(input logic [7:0] setl, input logic [7:0] pre, input logic [7:0] ratio, input int exp_len);
    int len, tog, ce_seen, highs;
    logic prev;
    wr(2'd1, setl);
    wr(2'd2, pre);
    wr(2'd0, ratio);
    chk("R3", "settling after write", int'(settling), 1);
    len = 0; tog = 0; ce_seen = 0; prev = ck_ext;
    while (settling && len < 20000) begin
      len++;
      ce_seen += int'(core_ce || per_ce);
      @(negedge clk);
      if (ck_ext != prev) tog++;
      prev = ck_ext;
    end
    chk("R4", "pause length", len, exp_len);
    chk("R3", "enables during pause", ce_seen, 0);
    chk("R6", "ck_ext toggles seen", int'(tog > 0), 1);
    chk("R5", "applied after wrap", act_all(), int'(ratio));
    quiet_cycles(40, highs);
    chk("R5", "no pause after wrap", highs, 0);
  endtask

  // R8: ratio write on the wrap edge is dropped
  task automatic t_wrap_overlap();
    int highs;
    wr(2'd1, 8'h00);
    wr(2'd2, 8'hFF);
    wr(2'd0, 8'h00);          // m=1, P=0: period 4, pause 4 cycles
    chk("R3", "settling after write", int'(settling), 1);
    repeat (2) @(negedge clk);
    wr(2'd0, 8'h02);          // lands on the wrap edge
    chk("R8", "settling after wrap", int'(settling), 0);
    chk("R8", "applied after overlap", act_all(), 8'h00);
    quiet_cycles(30, highs);
    chk("R8", "no second pause", highs, 0);
    chk("R8", "applied still first write", act_all(), 8'h00);
  endtask

  // R7: divider-only change
  task automatic t_div_only();
    int c, p, seen_set;
    logic prev_both;
    bit done;
    wr(2'd0, 8'h09);          // M=1 kept, C=2
    chk("R7", "settling after div write", int'(settling), 0);
    chk("R7", "applied unchanged at once", act_all(), 8'h01);
    done = 0; seen_set = 0;
    for (int i = 0; i < 50 && !done; i++) begin
      prev_both = core_ce && per_ce;
      seen_set += int'(settling);
      @(negedge clk);
      if (act_all() != 8'h01) begin
        chk("R7", "common pulse before apply", int'(prev_both), 1);
        chk("R7", "applied new dividers", act_all(), 8'h09);
        done = 1;
      end
    end
    chk("R7", "divider change applied", int'(done), 1);
    chk("R7", "no pause for divider change", seen_set, 0);
    count_ce(24, c, p);
    chk("R2", "core pulses 2x/3", c, 4);
    chk("R2", "per pulses 2x/1", p, 12);
  endtask

  // R9: multiplier change rejected while run bit set
  task automatic t_run_set();
    int highs;
    wr(2'd1, 8'h01);
    wr(2'd0, 8'h0B);
    quiet_cycles(30, highs);
    chk("R9", "no pause with run set", highs, 0);
    chk("R9", "applied unchanged", act_all(), 8'h09);
    wr(2'd1, 8'h00);
    quiet_cycles(30, highs);
    chk("R9", "nothing pending afterwards", act_all(), 8'h09);
  endtask

  // R10: identical write
  task automatic t_same();
    int highs;
    wr(2'd0, 8'h09);
    quiet_cycles(20, highs);
    chk("R10", "no pause on same value", highs, 0);
    chk("R10", "applied unchanged", act_all(), 8'h09);
  endtask

  initial begin
    int c, p;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    // M=3, P=1, S=1 (div 4), preload 0xFE: 2*4*2 = 16
    t_pause(8'h02, 8'hFE, 8'h23, 16);
    count_ce(16, c, p);
    chk("R2", "core pulses 4x/1", c, 16);
    chk("R2", "per pulses 4x/2", p, 8);
    t_wrap_overlap();
    // M=1, P=0, S=2 (div 16), preload 0xFF: 1*16*2 = 32
    t_pause(8'h04, 8'hFF, 8'h01, 32);
    t_div_only();
    t_run_set();
    t_same();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule